// File: doc/BRIEF.md
# Two-Master Registered Bus Arbiter

This block decides which of two bus masters drives the address phase of a shared pipelined bus. Each master raises a request line and watches its own grant line. Both grant lines come straight from flip-flops. A request therefore takes effect at a clock edge and shows on the grant one cycle later, and no combinational path runs from a request input to a grant output.

The arbiter takes the transfer type and burst type from the address phase on the bus. It compares them with a registered owner number, which names the master that holds the address phase. The grant moves to the other master only when all of these hold:

- the address phase belongs to the granted master;
- that master has dropped its request;
- the transfer on the bus is its last one: an idle cycle, a single transfer, the final beat of a fixed-length burst, or any beat of an open-ended burst.

A master that was granted sees its grant at an edge, starts its address phase, and only then can the arbiter see what it is doing. As a result a master that needs one single transfer keeps the grant for at least two cycles. It must drive idle cycles for whatever time remains. When nobody requests, the grant rests on master 0.

Top module: `arb2_bus_arbiter`

## Requirements
- R1: While reset is held and right after it, grant 0 is high, grant 1 is low and the owner number is 0.
- R2: A request from the non-granted master, seen at an edge where the granted master can release, raises that master's grant after the edge. A request change between edges never changes a grant within the same cycle.
- R3: When the granted master also owns the address phase, has its request low, and presents a non-sequential transfer (trans 2'b10) with single burst type (burst 3'b000) while ready is high, the grant moves to the other requesting master at that edge.
- R4: A grant that has just risen stays high for at least one further cycle, so every grant lasts at least two cycles.
- R5: During a fixed-length burst the grant is held until the sequential beat (trans 2'b11) that completes the burst is accepted. Burst codes 3'b010/3'b011 mean 4 beats, 3'b100/3'b101 mean 8, and 3'b110/3'b111 mean 16. For the open-ended burst code 3'b001, any beat with the request low ends ownership.
- R6: While ready is low, the grants, the owner number and the beat count do not change.
- R7: A granted master that keeps its request high keeps the grant.
- R8: When the owner releases and no master requests, or only master 0 requests, the grant goes to master 0. An idle cycle (trans 2'b00) with the request low counts as a release.
- R9: When ready is high at an edge, the owner number takes the index of the master that held the grant before that edge.
- R10: Exactly one grant output is high in every cycle.
- R11: A busy transfer (trans 2'b01) never ends ownership.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req0_i | input | 1 | Bus request from master 0 |
| req1_i | input | 1 | Bus request from master 1 |
| ready_i | input | 1 | Bus ready: the current transfer completes at this edge |
| trans_i | input | 2 | Transfer type of the address phase on the bus |
| burst_i | input | 3 | Burst type of the address phase on the bus |
| gnt0_o | output | 1 | Grant to master 0 (registered) |
| gnt1_o | output | 1 | Grant to master 1 (registered) |
| owner_o | output | 1 | Index of the master owning the address phase (registered) |

## Verification
The bench builds the block with the default beat-counter width of five bits. That width holds the longest fixed burst of sixteen beats, so the bench can run an 8-beat burst through to its final beat and exercise fixed bursts with and without ready stalls. Directed sequences cover:

- the two-cycle single-transfer handover;
- a 4-beat burst with a busy beat and a stall in it;
- an 8-beat burst;
- an open-ended burst;
- parking on master 0.

A long stretch of random requests, transfer types, burst types and ready stalls then compares the grants and the owner number against the behavioural model on every clock.

// File: rtl/arb2_pkg.sv
// Shared types for the two-master arbiter.
// Assumes the usual 2-bit transfer type and 3-bit burst type codes.
package arb2_pkg;

    typedef enum logic [1:0] {
        TR_IDLE = 2'b00,
        TR_BUSY = 2'b01,
        TR_NSEQ = 2'b10,
        TR_SEQ  = 2'b11
    } trans_e;

    localparam int TRANS_W = 2;
    localparam int BURST_W = 3;

    localparam logic [BURST_W-1:0] BU_SINGLE = 3'b000;
    localparam logic [BURST_W-1:0] BU_OPEN   = 3'b001;

    // Beats in a burst; 0 stands for the open-ended burst.
    function automatic int unsigned burst_beats(input logic [BURST_W-1:0] code);
        if (code == BU_SINGLE) return 1;
        if (code == BU_OPEN)   return 0;
        return 4 << ((int'(code) - 2) >> 1);
    endfunction

endpackage

// File: rtl/arb2_beat_tracker.sv
// Follows the beats of the address-phase burst on the bus and flags
// the transfer that ends the current owner's tenure.
// Assumes trans/burst come from the master owning the address phase.
module arb2_beat_tracker
    import arb2_pkg::*;
#(
    parameter int BEAT_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ready_i,
    input  logic [TRANS_W-1:0] trans_i,
    input  logic [BURST_W-1:0] burst_i,
    output logic               fin_o
);

    localparam int MAX_BEATS = 1 << (BEAT_W - 1);

    trans_e            tr;
    int unsigned       len;
    logic [BEAT_W-1:0] left_q;

    // Decode the bus controls.
    always_comb begin
        tr  = trans_e'(trans_i);
        len = burst_beats(burst_i);
    end

    // Count the beats still owed in a fixed burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (ready_i) begin
            if (tr == TR_NSEQ) begin
                left_q <= (len == 0) ? '0 : BEAT_W'(len - 1);
            end else if (tr == TR_SEQ && left_q != '0) begin
                left_q <= left_q - BEAT_W'(1);
            end
        end
    end

    // Decide whether the transfer on the bus is the owner's last.
    always_comb begin
        unique case (tr)
            TR_IDLE: fin_o = 1'b1;
            TR_NSEQ: fin_o = (len <= 1);
            TR_SEQ:  fin_o = (len == 0) || (left_q == BEAT_W'(1));
            default: fin_o = 1'b0;
        endcase
    end

    p_beats_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        left_q <= BEAT_W'(MAX_BEATS - 1));

    p_load_four_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_i && trans_i == 2'b10 && burst_i == 3'b011) |=> left_q == BEAT_W'(3));

    p_count_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_i |=> $stable(left_q));

    p_busy_no_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (trans_i == 2'b01) |-> !fin_o);

endmodule

// File: rtl/arb2_grant_ctrl.sv
// Holds the one-hot grant register and moves it on a release.
// Assumes owner_i names the address-phase owner, updated on ready.
module arb2_grant_ctrl #(
    parameter int N_MST = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_MST-1:0] req_i,
    input  logic             ready_i,
    input  logic             fin_i,
    input  logic             owner_i,
    output logic [N_MST-1:0] gnt_q,
    output logic             gnt_idx_o
);

    localparam logic [N_MST-1:0] PARK = N_MST'(1);

    logic             aligned;
    logic             release_now;
    logic [N_MST-1:0] pick;

    // Index of the granted master and release decision.
    always_comb begin
        gnt_idx_o   = gnt_q[1];
        aligned     = (owner_i == gnt_idx_o);
        release_now = ready_i && aligned && !req_i[gnt_idx_o] && fin_i;
    end

    // Fixed priority: master 0 first; park on master 0 when none requests.
    always_comb begin
        if (req_i[0])      pick = N_MST'(1);
        else if (req_i[1]) pick = N_MST'(2);
        else               pick = PARK;
    end

    // Update the grant register on a release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_q <= PARK;
        end else if (release_now) begin
            gnt_q <= pick;
        end
    end

    p_one_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gnt_q) == 1);

    p_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_i |=> $stable(gnt_q));

    p_min_two_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gnt_q[1]) |=> gnt_q[1]);

    p_min_two_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gnt_q[0]) |=> gnt_q[0]);

    p_park_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_i && req_i == '0 && gnt_q[1] && owner_i && fin_i) |=> gnt_q[0]);

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_i && gnt_q[0] && !owner_i && !req_i[0] && req_i[1] && fin_i) |=> gnt_q[1]);

    for (genvar m = 0; m < N_MST; m++) begin : g_hold
        p_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (gnt_q[m] && req_i[m]) |=> gnt_q[m]);
    end

endmodule

// File: rtl/arb2_owner_reg.sv
// Registers which master owns the address phase, one cycle behind the grant.
// Assumes ownership passes only on a ready edge.
module arb2_owner_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic ready_i,
    input  logic gnt_idx_i,
    output logic owner_q
);

    // Take the granted index when the bus advances.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q <= 1'b0;
        end else if (ready_i) begin
            owner_q <= gnt_idx_i;
        end
    end

    p_owner_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ready_i |=> owner_q == $past(gnt_idx_i));

    p_owner_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_i |=> $stable(owner_q));

endmodule

// File: rtl/arb2_bus_arbiter.sv
// Top of the two-master registered arbiter: beat tracking, grant
// register and owner register. Assumes trans/burst are the muxed
// address-phase controls of the current owner.
module arb2_bus_arbiter
    import arb2_pkg::*;
#(
    parameter int BEAT_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req0_i,
    input  logic               req1_i,
    input  logic               ready_i,
    input  logic [TRANS_W-1:0] trans_i,
    input  logic [BURST_W-1:0] burst_i,
    output logic               gnt0_o,
    output logic               gnt1_o,
    output logic               owner_o
);

    localparam int N_MST = 2;

    logic             fin;
    logic [N_MST-1:0] gnt;
    logic             gnt_idx;
    logic             owner;

    arb2_beat_tracker #(.BEAT_W(BEAT_W)) u_beats (
        .clk     (clk),
        .rst_n   (rst_n),
        .ready_i (ready_i),
        .trans_i (trans_i),
        .burst_i (burst_i),
        .fin_o   (fin)
    );

    arb2_grant_ctrl #(.N_MST(N_MST)) u_grant (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     ({req1_i, req0_i}),
        .ready_i   (ready_i),
        .fin_i     (fin),
        .owner_i   (owner),
        .gnt_q     (gnt),
        .gnt_idx_o (gnt_idx)
    );

    arb2_owner_reg u_owner (
        .clk       (clk),
        .rst_n     (rst_n),
        .ready_i   (ready_i),
        .gnt_idx_i (gnt_idx),
        .owner_q   (owner)
    );

    // Drive the ports from the registers.
    always_comb begin
        gnt0_o  = gnt[0];
        gnt1_o  = gnt[1];
        owner_o = owner;
    end

endmodule

// File: tb/test_arb2_bus_arbiter.sv
module test_arb2_bus_arbiter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req0 = 1'b0, req1 = 1'b0, ready = 1'b1;
    logic [1:0] trans = 2'b00;
    logic [2:0] burst = 3'b000;
    logic       gnt0, gnt1, owner;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // Behavioural model state
    int m_g = 0, m_own = 0, m_left = 0;

    always #10 clk = ~clk;

    arb2_bus_arbiter i_arb2_bus_arbiter (
        .clk(clk), .rst_n(rst_n), .req0_i(req0), .req1_i(req1),
        .ready_i(ready), .trans_i(trans), .burst_i(burst),
        .gnt0_o(gnt0), .gnt1_o(gnt1), .owner_o(owner)
    );

    // Reference model: advanced on every clock from the driven inputs.
    always @(posedge clk) begin
        int len;
        bit last;
        bit rq [2];
        int nxt;
        if (!rst_n) begin
            m_g = 0; m_own = 0; m_left = 0;
        end else if (ready) begin
            rq[0] = req0; rq[1] = req1;
            if (burst == 0)      len = 1;
            else if (burst == 1) len = 0;
            else                 len = 4 * (1 << ((burst - 2) / 2));
            case (trans)
                2'b00:   last = 1;
                2'b10:   last = (len <= 1);
                2'b11:   last = (len == 0) || (m_left == 1);
                default: last = 0;
            endcase
            nxt = m_g;
            if (m_own == m_g && !rq[m_g] && last) nxt = req0 ? 0 : (req1 ? 1 : 0);
            if (trans == 2'b10)                    m_left = (len == 0) ? 0 : len - 1;
            else if (trans == 2'b11 && m_left > 0) m_left = m_left - 1;
            m_own = m_g;
            m_g = nxt;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One clock: drive at negedge, sample at next negedge, compare with model.
    task automatic cyc(input bit r0, input bit r1, input bit rd,
                       input logic [1:0] tr, input logic [2:0] bu);
        req0 = r0; req1 = r1; ready = rd; trans = tr; burst = bu;
        @(posedge clk);
        @(negedge clk);
        chk("R10 one grant high", int'(gnt0) + int'(gnt1), 1);
        chk("R3 grant vs model", int'(gnt1), m_g);
        chk("R9 owner vs model", int'(owner), m_own);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset gnt0", int'(gnt0), 1);
        chk("R1 reset gnt1", int'(gnt1), 0);
        chk("R1 reset owner", int'(owner), 0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R1 after reset gnt0", int'(gnt0), 1);

        // Single-transfer handover
        req1 = 1'b1;
        #2 chk("R2 no combinational grant", int'(gnt1), 0);
        cyc(0, 1, 1, 2'b00, 3'b000); chk("R2 grant next cycle", int'(gnt1), 1);
        cyc(1, 0, 1, 2'b00, 3'b000); chk("R4 still granted", int'(gnt1), 1);
        chk("R9 owner moved", int'(owner), 1);
        cyc(1, 0, 1, 2'b10, 3'b000); chk("R3 single hands over", int'(gnt0), 1);
        cyc(1, 0, 1, 2'b00, 3'b000); chk("R9 owner back to 0", int'(owner), 0);

        // Hold while requesting, stall, then release
        cyc(1, 1, 1, 2'b10, 3'b000); chk("R7 requester keeps grant", int'(gnt0), 1);
        cyc(0, 1, 0, 2'b10, 3'b000); chk("R6 stalled no move", int'(gnt0), 1);
        cyc(0, 1, 1, 2'b10, 3'b000); chk("R3 release after stall", int'(gnt1), 1);

        // 4-beat burst with busy and stall
        cyc(0, 1, 1, 2'b00, 3'b000);
        cyc(1, 0, 1, 2'b10, 3'b011); chk("R5 burst start hold", int'(gnt1), 1);
        cyc(1, 0, 1, 2'b11, 3'b011); chk("R5 beat2 hold", int'(gnt1), 1);
        cyc(1, 0, 1, 2'b01, 3'b011); chk("R11 busy holds", int'(gnt1), 1);
        cyc(1, 0, 1, 2'b11, 3'b011); chk("R5 beat3 hold", int'(gnt1), 1);
        cyc(1, 0, 0, 2'b11, 3'b011); chk("R6 stall in burst", int'(gnt1), 1);
        cyc(1, 0, 1, 2'b11, 3'b011); chk("R5 last beat releases", int'(gnt0), 1);

        // Open-ended burst
        cyc(1, 0, 1, 2'b00, 3'b000);
        cyc(1, 1, 1, 2'b10, 3'b001); chk("R7 open burst held", int'(gnt0), 1);
        cyc(1, 1, 1, 2'b11, 3'b001); chk("R7 open burst beat", int'(gnt0), 1);
        cyc(0, 1, 1, 2'b11, 3'b001); chk("R5 open burst ends on drop", int'(gnt1), 1);

        // Parking
        cyc(0, 0, 1, 2'b00, 3'b000); chk("R4 hold before park", int'(gnt1), 1);
        cyc(0, 0, 1, 2'b00, 3'b000); chk("R8 park on 0", int'(gnt0), 1);
        cyc(0, 0, 1, 2'b00, 3'b000); chk("R8 stay parked", int'(gnt0), 1);

        // 8-beat burst by master 0
        cyc(0, 1, 1, 2'b10, 3'b101); chk("R5 8-beat start", int'(gnt0), 1);
        for (int i = 0; i < 6; i++) begin
            cyc(0, 1, 1, 2'b11, 3'b101); chk("R5 8-beat mid", int'(gnt0), 1);
        end
        cyc(0, 1, 1, 2'b11, 3'b101); chk("R5 8-beat end", int'(gnt1), 1);

        // Random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            cyc(1'($urandom), 1'($urandom), ($urandom % 5) != 0,
                2'($urandom), 3'($urandom));
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R10 actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule